// File: doc/BRIEF.md
# Host Interrupt Flag and Processor Control Unit

This block gathers six single-cycle event pulses from a display and microcode engine (microcode request, vertical blank, display format load, coprocessor shutdown, odd field start, even field start) into host-visible flags. It drives one active-low interrupt line toward the host. It also holds the processor's run/halt control and a few configuration bits. The host reaches it through a small register window. A write at word 0 loads the control word. A read at word 0 returns the flags and clears them. A read at word 1 returns the processor status together with the interrupt masks.

The flags are set whether or not the matching source is enabled, so the host can poll sources it has masked. An event that arrives in the same cycle as a clearing read survives the read. A separate sticky bit records a second microcode request that arrives before the host has read the flags. The masks read back from the status word at positions other than the ones they are written to, because a neighbouring decoder expects that layout.

Top module: `irq_ctl_unit`

## Requirements
- R1: After reset, halt_o is 1, step_o is 0, every enable is 0, sync_dis_o, pin_sel_o and native_o are 0, irq_n_o is 1 and a flag read returns 0.
- R2: A write (wr_en_i=1, wsel_i=0) loads control bits in the next cycle: bit 0 halt, bits 2..7 the enables for microcode, vertical blank, format load, shutdown, odd field and even field in that order, bit 12 sync_dis_o, bit 13 pin_sel_o, bit 15 native_o.
- R3: A write whose bits 0 and 1 are both 1, made while halt_o is already 1, raises step_o for exactly the following cycle and leaves halt_o at 1. The same write made while halt_o is 0 gives no pulse.
- R4: An event pulse sets its flag whatever its enable holds. A flag read (rd_en_i=1, wsel_i=0) returns, in the same cycle, bit 9 even field, bit 10 odd field, bit 12 shutdown, bit 13 microcode, bit 14 vertical blank and bit 15 format load, with bits 0..8 as 0.
- R5: A flag read clears all flags at the following edge. A status read and a control write leave the flags unchanged.
- R6: An event that coincides with a flag read is still set after that read.
- R7: Bit 11 of the flag word is set when a microcode event arrives while the microcode flag is already set. A flag read clears it.
- R8: A status read (rd_en_i=1, wsel_i=1) returns, in the same cycle, bit 0 = halt_o OR halt_pin_i, bit 1 freeze_i, bit 2 pmon_i, bit 3 sync_dis_o, and bits 10..15 the enables for microcode, vertical blank, format load, shutdown, odd field and even field, with all other bits 0.
- R9: irq_n_o is the registered inverse of the OR over sources of flag AND enable. It therefore goes low two edges after an enabled event.
- R10: A write with wsel_i=1 changes no control bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 6 | Event pulses: 0 microcode, 1 vertical blank, 2 format load, 3 shutdown, 4 odd field, 5 even field |
| wr_en_i | input | 1 | Host write strobe |
| rd_en_i | input | 1 | Host read strobe |
| wsel_i | input | 1 | Word select: 0 control/flags, 1 status |
| wdata_i | input | 16 | Host write data |
| rdata_o | output | 16 | Host read data, valid in the read cycle, 0 when no read |
| halt_pin_i | input | 1 | External halt request, shown in status |
| freeze_i | input | 1 | Processor freeze status |
| pmon_i | input | 1 | Performance monitor status |
| irq_n_o | output | 1 | Active-low host interrupt |
| halt_o | output | 1 | Processor halt |
| step_o | output | 1 | One-cycle single-step run pulse |
| sync_dis_o | output | 1 | Input synchronizer disable |
| pin_sel_o | output | 1 | Monitor pin function select |
| native_o | output | 1 | Native mode (1) or emulation mode (0) |

## Verification
Read data appears combinationally in the read cycle, so the bench samples rdata_o one time unit after it drives the strobe on a falling edge. Control outputs and step_o appear one edge after the write, so the bench checks them on the next falling edge. A flag appears one edge after its event and irq_n_o one edge later still, so every vector waits an idle cycle before it samples the interrupt line. The clearing read takes effect at the edge that closes the read cycle, which the bench observes with a second read.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;
   localparam int unsigned NUM_SRC     = 6;
   localparam int unsigned WORD_W      = 16;

   localparam int unsigned SRC_MCODE   = 0;
   localparam int unsigned SRC_VBLANK  = 1;
   localparam int unsigned SRC_FMTLD   = 2;
   localparam int unsigned SRC_SHUT    = 3;
   localparam int unsigned SRC_ODD     = 4;
   localparam int unsigned SRC_EVEN    = 5;

   localparam int unsigned CTL_HALT    = 0;
   localparam int unsigned CTL_STEP    = 1;
   localparam int unsigned CTL_EN_LSB  = 2;
   localparam int unsigned CTL_SYNC    = 12;
   localparam int unsigned CTL_PINSEL  = 13;
   localparam int unsigned CTL_NATIVE  = 15;

   localparam int unsigned FLG_REPEAT  = 11;

   localparam int unsigned STA_HALT    = 0;
   localparam int unsigned STA_FREEZE  = 1;
   localparam int unsigned STA_PMON    = 2;
   localparam int unsigned STA_SYNC    = 3;
   localparam int unsigned STA_MSK_LSB = 10;

   function automatic int unsigned flag_pos(input int unsigned src);
      case (src)
         SRC_MCODE:  return 13;
         SRC_VBLANK: return 14;
         SRC_FMTLD:  return 15;
         SRC_SHUT:   return 12;
         SRC_ODD:    return 10;
         default:    return 9;
      endcase
   endfunction
endpackage

// File: rtl/irq_flag_cell.sv
module irq_flag_cell #(
   parameter bit TRACK_REPEAT = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic evt_i,
   input  logic clr_i,
   output logic flag_o,
   output logic rep_o
);
   logic flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     flag_q <= 1'b0;
      else if (clr_i) flag_q <= evt_i;
      else            flag_q <= flag_q | evt_i;
   end
   assign flag_o = flag_q;

   generate
      if (TRACK_REPEAT) begin : g_rep
         logic rep_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     rep_q <= 1'b0;
            else if (clr_i) rep_q <= 1'b0;
            else            rep_q <= rep_q | (evt_i & flag_q);
         end
         assign rep_o = rep_q;

         AST_REPEAT_NEEDS_PRIOR: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(rep_o) |-> $past(flag_o && evt_i)); // R7
         AST_REPEAT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
            clr_i |=> !rep_o); // R7
      end else begin : g_norep
         assign rep_o = 1'b0;
      end
   endgenerate

   AST_EVT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      evt_i |=> flag_o); // R6
   AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !evt_i) |=> !flag_o); // R5
   AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i && flag_o) |=> flag_o); // R4
endmodule

// File: rtl/irq_ctl_reg.sv
module irq_ctl_reg
   import irq_ctl_pkg::*;
#(
   parameter int unsigned DW   = WORD_W,
   parameter int unsigned NSRC = NUM_SRC
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_i,
   input  logic [DW-1:0]   wdata_i,
   output logic            halt_o,
   output logic            step_o,
   output logic [NSRC-1:0] en_o,
   output logic            sync_dis_o,
   output logic            pin_sel_o,
   output logic            native_o
);
   localparam int unsigned EN_MSB = CTL_EN_LSB + NSRC - 1;

   logic            halt_q, step_q, sync_q, pin_q, native_q;
   logic [NSRC-1:0] en_q;
   logic            step_req;
   logic            unused_wbits;

   assign step_req     = wr_i & wdata_i[CTL_STEP] & wdata_i[CTL_HALT] & halt_q;
   assign unused_wbits = ^{wdata_i[CTL_SYNC-1:EN_MSB+1], wdata_i[CTL_NATIVE-1:CTL_PINSEL+1]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         halt_q   <= 1'b1;
         step_q   <= 1'b0;
         en_q     <= '0;
         sync_q   <= 1'b0;
         pin_q    <= 1'b0;
         native_q <= 1'b0;
      end else begin
         step_q <= step_req;
         if (wr_i) begin
            halt_q   <= wdata_i[CTL_HALT];
            en_q     <= wdata_i[EN_MSB:CTL_EN_LSB];
            sync_q   <= wdata_i[CTL_SYNC];
            pin_q    <= wdata_i[CTL_PINSEL];
            native_q <= wdata_i[CTL_NATIVE];
         end
      end
   end

   assign halt_o     = halt_q;
   assign step_o     = step_q;
   assign en_o       = en_q;
   assign sync_dis_o = sync_q;
   assign pin_sel_o  = pin_q;
   assign native_o   = native_q;

   AST_STEP_NEEDS_HALT: assert property (@(posedge clk) disable iff (!rst_n)
      step_o |-> halt_o); // R3
   AST_STEP_FROM_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(step_o) |-> $past(halt_o)); // R3
   AST_WRITE_LOADS_HALT: assert property (@(posedge clk) disable iff (!rst_n)
      wr_i |=> (halt_o == $past(wdata_i[CTL_HALT]))); // R2
   AST_NO_WRITE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_i |=> ($stable(en_o) && $stable(halt_o) && $stable(native_o))); // R10
endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux
   import irq_ctl_pkg::*;
#(
   parameter int unsigned DW   = WORD_W,
   parameter int unsigned NSRC = NUM_SRC
) (
   input  logic            rd_flag_i,
   input  logic            rd_stat_i,
   input  logic [NSRC-1:0] flags_i,
   input  logic            repeat_i,
   input  logic [NSRC-1:0] en_i,
   input  logic            halt_i,
   input  logic            freeze_i,
   input  logic            pmon_i,
   input  logic            sync_dis_i,
   output logic [DW-1:0]   rdata_o
);
   logic [DW-1:0] flag_word, stat_word;

   always_comb begin
      flag_word = '0;
      for (int unsigned i = 0; i < NSRC; i++) begin
         flag_word[flag_pos(i)] = flags_i[i];
      end
      flag_word[FLG_REPEAT] = repeat_i;
   end

   always_comb begin
      stat_word = '0;
      stat_word[STA_HALT]   = halt_i;
      stat_word[STA_FREEZE] = freeze_i;
      stat_word[STA_PMON]   = pmon_i;
      stat_word[STA_SYNC]   = sync_dis_i;
      stat_word[STA_MSK_LSB +: NSRC] = en_i;
   end

   always_comb begin
      if (rd_flag_i)      rdata_o = flag_word;
      else if (rd_stat_i) rdata_o = stat_word;
      else                rdata_o = '0;
   end

   always_comb begin
      assert (!(rd_flag_i && rd_stat_i)); // R5
   end
endmodule

// File: rtl/irq_ctl_unit.sv
module irq_ctl_unit
   import irq_ctl_pkg::*;
#(
   parameter int unsigned DW       = WORD_W,
   parameter int unsigned NSRC     = NUM_SRC,
   parameter int unsigned WSEL_W   = 1,
   parameter bit          IRQ_REG  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NSRC-1:0]   evt_i,
   input  logic              wr_en_i,
   input  logic              rd_en_i,
   input  logic [WSEL_W-1:0] wsel_i,
   input  logic [DW-1:0]     wdata_i,
   output logic [DW-1:0]     rdata_o,
   input  logic              halt_pin_i,
   input  logic              freeze_i,
   input  logic              pmon_i,
   output logic              irq_n_o,
   output logic              halt_o,
   output logic              step_o,
   output logic              sync_dis_o,
   output logic              pin_sel_o,
   output logic              native_o
);
   localparam logic [WSEL_W-1:0] SEL_MAIN = WSEL_W'(0);
   localparam logic [WSEL_W-1:0] SEL_STAT = WSEL_W'(1);

   generate
      if (DW != 16) begin : g_bad_width
         $error("irq_ctl_unit: DW must be 16 for the fixed register layout");
      end
      if (NSRC != 6) begin : g_bad_src
         $error("irq_ctl_unit: NSRC must be 6");
      end
   endgenerate

   logic            wr_ctl, rd_flag, rd_stat;
   logic [NSRC-1:0] flag_vec, rep_vec, en_vec;
   logic            irq_any;

   assign wr_ctl  = wr_en_i & (wsel_i == SEL_MAIN);
   assign rd_flag = rd_en_i & (wsel_i == SEL_MAIN);
   assign rd_stat = rd_en_i & (wsel_i == SEL_STAT);

   irq_ctl_reg #(.DW(DW), .NSRC(NSRC)) u_ctl (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_i       (wr_ctl),
      .wdata_i    (wdata_i),
      .halt_o     (halt_o),
      .step_o     (step_o),
      .en_o       (en_vec),
      .sync_dis_o (sync_dis_o),
      .pin_sel_o  (pin_sel_o),
      .native_o   (native_o)
   );

   generate
      for (genvar s = 0; s < NSRC; s++) begin : g_src
         irq_flag_cell #(.TRACK_REPEAT(s == SRC_MCODE)) u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .evt_i  (evt_i[s]),
            .clr_i  (rd_flag),
            .flag_o (flag_vec[s]),
            .rep_o  (rep_vec[s])
         );
      end
   endgenerate

   irq_read_mux #(.DW(DW), .NSRC(NSRC)) u_mux (
      .rd_flag_i  (rd_flag),
      .rd_stat_i  (rd_stat),
      .flags_i    (flag_vec),
      .repeat_i   (|rep_vec),
      .en_i       (en_vec),
      .halt_i     (halt_o | halt_pin_i),
      .freeze_i   (freeze_i),
      .pmon_i     (pmon_i),
      .sync_dis_i (sync_dis_o),
      .rdata_o    (rdata_o)
   );

   assign irq_any = |(flag_vec & en_vec);

   generate
      if (IRQ_REG) begin : g_irq_reg
         logic irq_n_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_n_q <= 1'b1;
            else        irq_n_q <= ~irq_any;
         end
         assign irq_n_o = irq_n_q;

         AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
            !irq_n_o |-> $past(|(flag_vec & en_vec))); // R9
         AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            !(|(flag_vec & en_vec)) |=> irq_n_o); // R9
      end else begin : g_irq_comb
         assign irq_n_o = ~irq_any;
      end
   endgenerate

   AST_STATUS_READ_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stat && !(|evt_i)) |=> $stable(flag_vec)); // R5
endmodule

// File: tb/irq_ctl_unit_bench.sv
module irq_ctl_unit_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [5:0]  evt = '0;
   logic        wr = 1'b0, rd = 1'b0, sel = 1'b0;
   logic [15:0] wd = '0;
   logic [15:0] rdata;
   logic        hpin = 1'b0, frz = 1'b0, pmon = 1'b0;
   logic        irq_n, halt, step, sdis, psel, nat;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   irq_ctl_unit u_irq_ctl_unit (
      .clk(clk), .rst_n(rst_n), .evt_i(evt), .wr_en_i(wr), .rd_en_i(rd),
      .wsel_i(sel), .wdata_i(wd), .rdata_o(rdata), .halt_pin_i(hpin),
      .freeze_i(frz), .pmon_i(pmon), .irq_n_o(irq_n), .halt_o(halt),
      .step_o(step), .sync_dis_o(sdis), .pin_sel_o(psel), .native_o(nat)
   );

   // {events[5:0], enables[5:0], expected irq_n}
   localparam logic [12:0] VEC [8] = '{
      {6'b000001, 6'b000001, 1'b0},
      {6'b000010, 6'b000001, 1'b1},
      {6'b100000, 6'b100000, 1'b0},
      {6'b010100, 6'b000100, 1'b0},
      {6'b101010, 6'b010101, 1'b1},
      {6'b111111, 6'b000000, 1'b1},
      {6'b001000, 6'b111111, 1'b0},
      {6'b000000, 6'b111111, 1'b1}
   };

   function automatic logic [15:0] exp_flags(input logic [5:0] e);
      logic [15:0] w;
      w = '0;
      w[13] = e[0]; w[14] = e[1]; w[15] = e[2];
      w[12] = e[3]; w[10] = e[4]; w[9]  = e[5];
      return w;
   endfunction

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic drive(input logic w, input logic r, input logic s,
                        input logic [15:0] d, input logic [5:0] e);
      @(negedge clk);
      wr = w; rd = r; sel = s; wd = d; evt = e;
      #1;
   endtask

   task automatic idle();
      drive(1'b0, 1'b0, 1'b0, 16'h0000, 6'b0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      idle();
      // R1 reset state
      chk("R1 halt", {15'b0, halt}, 16'h0001);
      chk("R1 cfg", {12'b0, step, sdis, psel, nat}, 16'h0000);
      chk("R1 irq", {15'b0, irq_n}, 16'h0001);
      drive(1'b0, 1'b1, 1'b0, 16'h0, 6'b0);
      chk("R1 flags", rdata, 16'h0000);
      drive(1'b0, 1'b1, 1'b1, 16'h0, 6'b0);
      chk("R1 status", rdata, 16'h0001);

      // table walk: R4, R5, R9
      for (int v = 0; v < 8; v++) begin
         logic [5:0] ev, en;
         logic       xi;
         {ev, en, xi} = VEC[v];
         drive(1'b1, 1'b0, 1'b0, {8'b0, en, 2'b01}, 6'b0);
         drive(1'b0, 1'b0, 1'b0, 16'h0, ev);
         idle();
         drive(1'b0, 1'b1, 1'b0, 16'h0, 6'b0);
         chk($sformatf("R9 irq vec %0d", v), {15'b0, irq_n}, {15'b0, xi});
         chk($sformatf("R4 flags vec %0d", v), rdata, exp_flags(ev));
         drive(1'b0, 1'b1, 1'b0, 16'h0, 6'b0);
         chk($sformatf("R5 cleared vec %0d", v), rdata, 16'h0000);
         idle();
         chk($sformatf("R9 irq release vec %0d", v), {15'b0, irq_n}, 16'h0001);
      end

      // R2 control fields
      drive(1'b1, 1'b0, 1'b0, 16'hB0FD, 6'b0);
      drive(1'b0, 1'b1, 1'b1, 16'h0, 6'b0);
      chk("R2 cfg", {12'b0, halt, sdis, psel, nat}, 16'h000F);
      chk("R8 status all masks", rdata, 16'hFC09);
      // R10 write at status word ignored
      drive(1'b1, 1'b0, 1'b1, 16'h0000, 6'b0);
      drive(1'b0, 1'b1, 1'b1, 16'h0, 6'b0);
      chk("R10 status kept", rdata, 16'hFC09);
      chk("R10 cfg kept", {12'b0, halt, sdis, psel, nat}, 16'h000F);
      frz = 1'b1; pmon = 1'b1;
      drive(1'b0, 1'b1, 1'b1, 16'h0, 6'b0);
      chk("R8 freeze pmon", rdata, 16'hFC0F);
      frz = 1'b0; pmon = 1'b0;
      drive(1'b1, 1'b0, 1'b0, 16'h0015, 6'b0);
      drive(1'b0, 1'b1, 1'b1, 16'h0, 6'b0);
      chk("R8 mask positions", rdata, 16'h1401);
      chk("R2 cfg cleared", {13'b0, sdis, psel, nat}, 16'h0000);
      drive(1'b1, 1'b0, 1'b0, 16'h0000, 6'b0);
      drive(1'b0, 1'b1, 1'b1, 16'h0, 6'b0);
      chk("R2 halt cleared", rdata, 16'h0000);
      hpin = 1'b1;
      drive(1'b0, 1'b1, 1'b1, 16'h0, 6'b0);
      chk("R8 halt pin", rdata, 16'h0001);
      hpin = 1'b0;

      // R3 single step
      drive(1'b1, 1'b0, 1'b0, 16'h0003, 6'b0);
      idle();
      chk("R3 no step when running", {14'b0, halt, step}, 16'h0002);
      drive(1'b1, 1'b0, 1'b0, 16'h0003, 6'b0);
      idle();
      chk("R3 step pulse", {14'b0, halt, step}, 16'h0003);
      idle();
      chk("R3 step ends", {14'b0, halt, step}, 16'h0002);

      // R6 event during clearing read
      drive(1'b0, 1'b0, 1'b0, 16'h0, 6'b000001);
      drive(1'b0, 1'b1, 1'b0, 16'h0, 6'b100000);
      chk("R6 first read", rdata, 16'h2000);
      drive(1'b0, 1'b1, 1'b0, 16'h0, 6'b0);
      chk("R6 survivor", rdata, 16'h0200);

      // R7 repeat flag
      drive(1'b0, 1'b0, 1'b0, 16'h0, 6'b000001);
      drive(1'b0, 1'b0, 1'b0, 16'h0, 6'b000001);
      drive(1'b0, 1'b1, 1'b0, 16'h0, 6'b0);
      chk("R7 repeat set", rdata, 16'h2800);
      drive(1'b0, 1'b1, 1'b0, 16'h0, 6'b0);
      chk("R7 repeat cleared", rdata, 16'h0000);
      drive(1'b0, 1'b0, 1'b0, 16'h0, 6'b000001);
      drive(1'b0, 1'b1, 1'b0, 16'h0, 6'b0);
      drive(1'b0, 1'b0, 1'b0, 16'h0, 6'b000001);
      drive(1'b0, 1'b1, 1'b0, 16'h0, 6'b0);
      chk("R7 no repeat across read", rdata, 16'h2000);

      // R5 status read and write leave flags
      drive(1'b0, 1'b0, 1'b0, 16'h0, 6'b000010);
      drive(1'b0, 1'b1, 1'b1, 16'h0, 6'b0);
      drive(1'b1, 1'b0, 1'b0, 16'h0001, 6'b0);
      drive(1'b0, 1'b1, 1'b0, 16'h0, 6'b0);
      chk("R5 flags kept", rdata, 16'h4000);
      idle();

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule